// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit effective address from a base value, an index value that may be shifted left by a scale code, and a signed displacement. A two-bit mode input chooses which of these terms go into the sum. The register file and decode logic supply the operands, and the block returns the address one clock later.

The result leaves the block in one of two ways. Normally it goes out as a memory request strobe. When the load-address flag is set, the same sum comes out with a result strobe and no memory request is raised, so the caller can write the address into a destination register. The sum wraps modulo 2^32 and never traps.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 gives base + displacement, and the index and scale inputs have no effect.
- R2: Mode code 1 gives base + index. Scale and displacement have no effect.
- R3: Mode code 2 gives base + (index shifted left by the scale code), and the displacement has no effect.
- R4: Mode code 3 gives base + (index shifted left by the scale code) + displacement, all in one operation.
- R5: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R6: When `disp_wide_i` is 0, only bits [7:0] of the displacement are used, sign-extended from bit 7, and the upper bits are ignored. When it is 1, all 32 bits are used as a signed value.
- R7: The address wraps modulo 2^32.
- R8: If `valid_i` is high with `lea_i` low at a rising edge, then after that edge `mem_req_o` is high, `res_vld_o` is low and `addr_o` holds the sum.
- R9: If `valid_i` is high with `lea_i` high at a rising edge, then after that edge `res_vld_o` is high, `mem_req_o` is low and `addr_o` holds the sum.
- R10: A rising edge with `valid_i` low leaves both strobes low and `addr_o` unchanged.
- R11: While `rst_ni` is low, `addr_o`, `mem_req_o` and `res_vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| mode_i | input | 2 | Term selection code (0..3) |
| lea_i | input | 1 | Return the sum as a register result instead of a memory request |
| base_i | input | 32 | Base value |
| index_i | input | 32 | Index value |
| scale_i | input | 2 | Left-shift amount for the index |
| disp_i | input | 32 | Displacement |
| disp_wide_i | input | 1 | 1: 32-bit displacement, 0: 8-bit sign-extended displacement |
| addr_o | output | 32 | Registered effective address |
| mem_req_o | output | 1 | Memory request strobe |
| res_vld_o | output | 1 | Load-address result strobe |

## Verification
The bench goes after the cases where a term must drop out of the sum: a nonzero index in mode 0, and a nonzero scale and displacement in modes 1 and 2. A design that decodes the mode wrongly returns an address offset by exactly the term it should have left out. It also feeds narrow displacements whose bit 7 is set, with junk in the upper bits. A design that zero-extends, or that reads the full word, gives an address that is off by 0x100 or by the junk value. Sums that cross 2^32 check the wrap, and load-address cycles check that no memory request goes out. Idle cycles check that the address holds and that neither strobe fires.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    EA_BD   = 2'd0,
    EA_BI   = 2'd1,
    EA_BSI  = 2'd2,
    EA_BSID = 2'd3
  } ea_mode_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int AW = 32,
  parameter int NW = 8
) (
  input  logic [AW-1:0] disp_i,
  input  logic          wide_i,
  output logic [AW-1:0] disp_o
);
  localparam int EXT_W = AW - NW;
  logic [AW-1:0] narrow;
  assign narrow = {{EXT_W{disp_i[NW-1]}}, disp_i[NW-1:0]};
  assign disp_o = wide_i ? disp_i : narrow;
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] scaled_o
);
  localparam int NSH = 1 << SW;
  logic [AW-1:0] sh [NSH];
  for (genvar g = 0; g < NSH; g++) begin : g_sh
    assign sh[g] = index_i << g;
  end
  assign scaled_o = sh[scale_i];
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] sum_o
);
  // carry out of bit AW-1 is dropped: modulo 2^AW
  assign sum_o = base_i + idx_i + disp_i;
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          lea_i,
  input  logic [AW-1:0] sum_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_req_o,
  output logic          res_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      mem_req_o <= 1'b0;
      res_vld_o <= 1'b0;
    end else begin
      mem_req_o <= valid_i & ~lea_i;
      res_vld_o <= valid_i & lea_i;
      if (valid_i) addr_o <= sum_i;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 2,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    mode_i,
  input  logic          lea_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  input  logic [AW-1:0] disp_i,
  input  logic          disp_wide_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_req_o,
  output logic          res_vld_o
);
  ea_mode_e      mode;
  logic [AW-1:0] disp_ext, idx_scaled, idx_term, disp_term, sum;

  assign mode = ea_mode_e'(mode_i);

  ea_disp_ext #(.AW(AW), .NW(NW)) u_disp (
    .disp_i (disp_i),
    .wide_i (disp_wide_i),
    .disp_o (disp_ext)
  );

  ea_index_scale #(.AW(AW), .SW(SW)) u_scale (
    .index_i  (index_i),
    .scale_i  (scale_i),
    .scaled_o (idx_scaled)
  );

  always_comb begin
    idx_term  = '0;
    disp_term = '0;
    unique case (mode)
      EA_BD:   disp_term = disp_ext;
      EA_BI:   idx_term  = index_i;
      EA_BSI:  idx_term  = idx_scaled;
      EA_BSID: begin
        idx_term  = idx_scaled;
        disp_term = disp_ext;
      end
      default: ;
    endcase
  end

  ea_sum #(.AW(AW)) u_sum (
    .base_i (base_i),
    .idx_i  (idx_term),
    .disp_i (disp_term),
    .sum_o  (sum)
  );

  ea_out_reg #(.AW(AW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .lea_i     (lea_i),
    .sum_i     (sum),
    .addr_o    (addr_o),
    .mem_req_o (mem_req_o),
    .res_vld_o (res_vld_o)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [1:0]    mode_i,
  input logic          lea_i,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] index_i,
  input logic [AW-1:0] disp_i,
  input logic          disp_wide_i,
  input logic [AW-1:0] addr_o,
  input logic          mem_req_o,
  input logic          res_vld_o
);
  p_bd_wide_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'd0 && disp_wide_i |=> addr_o == AW'($past(base_i) + $past(disp_i)));

  p_bi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'd1 |=> addr_o == AW'($past(base_i) + $past(index_i)));

  p_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !lea_i |=> mem_req_o && !res_vld_o);

  p_lea_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && lea_i |=> res_vld_o && !mem_req_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !mem_req_o && !res_vld_o && $stable(addr_o));

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && res_vld_o));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .mode_i      (mode_i),
  .lea_i       (lea_i),
  .base_i      (base_i),
  .index_i     (index_i),
  .disp_i      (disp_i),
  .disp_wide_i (disp_wide_i),
  .addr_o      (addr_o),
  .mem_req_o   (mem_req_o),
  .res_vld_o   (res_vld_o)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        lea_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [31:0] index_i = '0;
  logic [1:0]  scale_i = '0;
  logic [31:0] disp_i = '0;
  logic        disp_wide_i = 1'b0;
  logic [31:0] addr_o;
  logic        mem_req_o, res_vld_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ea_gen u_dut (
    .clk_i, .rst_ni, .valid_i, .mode_i, .lea_i, .base_i, .index_i,
    .scale_i, .disp_i, .disp_wide_i, .addr_o, .mem_req_o, .res_vld_o
  );

  localparam int N = 11;
  // columns: mode, lea, wide, base, index, scale, disp, requirement
  localparam logic [1:0]  V_MODE [N] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd3, 2'd3, 2'd2, 2'd0};
  localparam logic        V_LEA  [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        V_WIDE [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_BASE [N] = '{32'h1000, 32'h1000, 32'h1000_0000, 32'h2000, 32'h2000,
                                         32'h2000, 32'h2000, 32'h4000, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h8000};
  localparam logic [31:0] V_IDX  [N] = '{32'hDEAD_0000, 32'h0, 32'h234, 32'h10, 32'h10,
                                         32'h10, 32'h10, 32'h8, 32'h4, 32'h4, 32'h0};
  localparam logic [1:0]  V_SCL  [N] = '{2'd3, 2'd0, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd2, 2'd2, 2'd0};
  localparam logic [31:0] V_DISP [N] = '{32'h10, 32'h1234_5680, 32'h55, 32'h99, 32'h99,
                                         32'h99, 32'h99, 32'h0000_00FC, 32'h10, 32'h77, 32'hFFFF_FF00};
  // R1 R6 R2 R3/R5 R5 R5 R9 R4/R6 R7/R9 R7 R1/R9
  localparam int          V_REQ  [N] = '{1, 6, 2, 3, 5, 5, 9, 4, 7, 7, 1};

  function automatic logic [31:0] ref_ea(input logic [1:0] m, input logic w,
                                         input logic [31:0] b, input logic [31:0] x,
                                         input logic [1:0] s, input logic [31:0] d);
    logic [31:0] dd, xs;
    dd = w ? d : {{24{d[7]}}, d[7:0]};
    xs = x * (32'd1 << s);
    case (m)
      2'd0: return b + dd;
      2'd1: return b + x;
      2'd2: return b + xs;
      default: return b + xs + dd;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic l, input logic w,
                       input logic [31:0] b, input logic [31:0] x, input logic [1:0] s,
                       input logic [31:0] d);
    valid_i = v; mode_i = m; lea_i = l; disp_wide_i = w;
    base_i = b; index_i = x; scale_i = s; disp_i = d;
  endtask

  initial begin
    logic [31:0] held;
    // R11: reset holds outputs at zero even with valid asserted
    drive(1'b1, 2'd3, 1'b0, 1'b1, 32'h1234, 32'h1, 2'd1, 32'h1);
    repeat (3) @(negedge clk_i);
    chk(addr_o, 32'h0, "R11 addr");
    chk({31'b0, mem_req_o}, 32'h0, "R11 mem_req");
    chk({31'b0, res_vld_o}, 32'h0, "R11 res_vld");
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: drive at negedge, one posedge, sample at next negedge
    for (int i = 0; i < N; i++) begin
      logic [31:0] e;
      string t;
      drive(1'b1, V_MODE[i], V_LEA[i], V_WIDE[i], V_BASE[i], V_IDX[i], V_SCL[i], V_DISP[i]);
      e = ref_ea(V_MODE[i], V_WIDE[i], V_BASE[i], V_IDX[i], V_SCL[i], V_DISP[i]);
      @(negedge clk_i);
      t = $sformatf("R%0d vec%0d", V_REQ[i], i);
      chk(addr_o, e, {t, " addr"});
      chk({31'b0, mem_req_o}, {31'b0, ~V_LEA[i]}, {t, " mem_req R8"});
      chk({31'b0, res_vld_o}, {31'b0, V_LEA[i]}, {t, " res_vld R9"});
    end

    // hand-computed corner values
    drive(1'b1, 2'd1, 1'b0, 1'b0, 32'h100, 32'h3, 2'd3, 32'hFF);
    @(negedge clk_i);
    chk(addr_o, 32'h103, "R2 scale/disp ignored");
    drive(1'b1, 2'd0, 1'b0, 1'b0, 32'h1000, 32'hFFFF_FFFF, 2'd3, 32'hABCD_EF80);
    @(negedge clk_i);
    chk(addr_o, 32'h0F80, "R6 narrow sign-extend");
    drive(1'b1, 2'd3, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h1, 2'd3, 32'hFFFF_FFF9);
    @(negedge clk_i);
    chk(addr_o, 32'h0000_0000, "R7 wrap three terms R4");

    // R10: idle cycles with changing operands keep addr and drop strobes
    held = addr_o;
    drive(1'b0, 2'd3, 1'b0, 1'b1, 32'h5555_5555, 32'h7, 2'd2, 32'h9);
    @(negedge clk_i);
    chk(addr_o, held, "R10 addr hold");
    chk({31'b0, mem_req_o}, 32'h0, "R10 mem_req low");
    base_i = 32'h0;
    @(negedge clk_i);
    chk(addr_o, held, "R10 addr hold 2");
    chk({31'b0, res_vld_o}, 32'h0, "R10 res_vld low");

    // back-to-back lea then request
    drive(1'b1, 2'd2, 1'b1, 1'b1, 32'h10, 32'h2, 2'd3, 32'h0);
    @(negedge clk_i);
    chk(addr_o, 32'h20, "R9 b2b addr");
    chk({31'b0, res_vld_o}, 32'h1, "R9 b2b res_vld");
    lea_i = 1'b0;
    @(negedge clk_i);
    chk({31'b0, mem_req_o}, 32'h1, "R8 b2b mem_req");
    chk({31'b0, res_vld_o}, 32'h0, "R8 b2b res_vld");

    // R11: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk(addr_o, 32'h0, "R11 async addr");
    chk({31'b0, mem_req_o}, 32'h0, "R11 async mem_req");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule